// File: doc/BRIEF.md
# Receiver Polling Cycle Controller

This block sequences a low-power radio receiver through a repeating duty cycle. In the sleep phase the signal-processing circuitry is switched off. In the startup phase it is switched on and allowed to settle for a fixed number of clocks. In the check phase an external bit checker judges the incoming stream and reports pass, fail or valid pulses. A failed check sends the block back to sleep. A valid signal moves it into a receiving phase and raises a wake line to the host. The host pulses an acknowledge input to return the block to polling.

The sleep length is the product of a 5-bit sleep word, an extension factor of 1 or 8, and a parameterised tick unit of base clocks. The unit is 1024 by default. Two configuration bits select the factor of 8. The standard bit applies it to every sleep. The temporary bit applies it only until a check fails; the failure clears the bit. A sleep word of all ones holds the block asleep until a different word is written.

Top module: `rx_poll_ctrl`

## Requirements
- R1: Phases follow the order sleep, startup, check. From check the block goes either to sleep or to receiving, and from receiving it goes to sleep. `phase_o` encodes sleep=0, startup=1, check=2, receiving=3.
- R2: `proc_en` is low throughout sleep and high in startup, check and receiving.
- R3: A sleep phase lasts word × factor × TICK_UNIT clocks, where the factor is 1 unless extended. A word of 0 gives a one-clock sleep.
- R4: With the standard extension bit (`cfg_xstd`) set, every sleep uses factor 8, including sleeps that follow a failed check.
- R5: With the temporary extension bit (`cfg_xtmp`) set, sleeps use factor 8. A `bc_fail` pulse in check clears the bit, so later sleeps use factor 1 until the bit is written again.
- R6: Startup lasts STARTUP_CYCLES clocks, then check begins.
- R7: In check, `bc_fail` moves the block to sleep on the next clock. `bc_pass` pulses leave it in check.
- R8: In check, `bc_valid` moves the block to receiving and takes priority over `bc_fail`. `wake_o` is high exactly while receiving. A `host_ack` pulse returns the block to sleep.
- R9: A sleep entered with word 31 is permanent and ignores the timer. Writing any other word during that sleep moves the block to startup on the next clock.
- R10: A configuration write (`cfg_we` with `cfg_sleep`, `cfg_xstd`, `cfg_xtmp`) changes nothing in a sleep already in progress. It takes effect at the next entry into sleep.
- R11: After reset the block is in sleep with `wake_o` low. The configuration is word RST_SLEEP with both extension bits clear, and the first sleep uses that configuration.
- R12: Bit-check pulses outside the check phase have no effect on the phase sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sleep | input | 5 | Sleep word to write |
| cfg_xstd | input | 1 | Standard extension bit to write |
| cfg_xtmp | input | 1 | Temporary extension bit to write |
| bc_pass | input | 1 | Bit checker pass pulse |
| bc_fail | input | 1 | Bit checker fail pulse |
| bc_valid | input | 1 | Bit checker valid-signal pulse |
| host_ack | input | 1 | Host pulse returning the block to polling |
| proc_en | output | 1 | Signal-processing enable |
| wake_o | output | 1 | Wake request to the host |
| phase_o | output | 2 | Current phase (0 sleep, 1 startup, 2 check, 3 receiving) |

## Verification
The assertions check the following on every clock:
- the legal phase successions and the enable level in sleep;
- that wake is held until acknowledge;
- that permanent sleep holds, and that it is left at once on a write;
- that a failed check clears the temporary bit.

Sleep and startup durations, the multiplication by the extension factor, and the deferral of writes to the next sleep depend on counted intervals. Only the bench's directed scenarios show these, by timing each phase in clocks.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

    typedef enum logic [1:0] {
        PH_SLEEP = 2'd0,
        PH_START = 2'd1,
        PH_CHECK = 2'd2,
        PH_RECV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [4:0] word;
        logic       x_std;
        logic       x_tmp;
    } poll_cfg_t;

    localparam logic [4:0]  SLEEP_FOREVER = 5'h1F;
    localparam int unsigned EXT_MULT      = 8;

    function automatic int unsigned sleep_len(input logic [4:0] w,
                                              input logic ext,
                                              input int unsigned unit);
        int unsigned f;
        f = ext ? EXT_MULT : 1;
        return 32'(w) * f * unit;
    endfunction

endpackage

// File: rtl/rx_poll_cfg.sv
module rx_poll_cfg
    import rx_poll_pkg::*;
#(
    parameter logic [4:0] RST_WORD = 5'd11
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      we,
    input  poll_cfg_t wr,
    input  logic      tmp_clr,
    output poll_cfg_t cfg_nxt
);
    poll_cfg_t cfg_q;

    always_comb begin
        cfg_nxt = cfg_q;
        if (tmp_clr) cfg_nxt.x_tmp = 1'b0;
        if (we)      cfg_nxt = wr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.word  <= RST_WORD;
            cfg_q.x_std <= 1'b0;
            cfg_q.x_tmp <= 1'b0;
        end else begin
            cfg_q <= cfg_nxt;
        end
    end
endmodule

// File: rtl/rx_poll_timer.sv
module rx_poll_timer #(
    parameter int unsigned    W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         expired
);
    logic [W-1:0] cnt;

    assign expired = (cnt <= W'(1));

    always_ff @(posedge clk) begin
        if (rst)                       cnt <= RST_VAL;
        else if (load)                 cnt <= load_val;
        else if (run && cnt != '0)     cnt <= cnt - W'(1);
    end
endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
    import rx_poll_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_done,
    input  logic   start_done,
    input  logic   perm_q,
    input  logic   wake_perm,
    input  logic   bc_fail,
    input  logic   bc_valid,
    input  logic   host_ack,
    output phase_e phase,
    output logic   enter_sleep,
    output logic   enter_start,
    output logic   tmp_clr
);
    phase_e nxt;

    always_comb begin
        nxt     = phase;
        tmp_clr = 1'b0;
        unique case (phase)
            PH_SLEEP: begin
                if (perm_q) begin
                    if (wake_perm) nxt = PH_START;
                end else if (sleep_done) begin
                    nxt = PH_START;
                end
            end
            PH_START: if (start_done) nxt = PH_CHECK;
            PH_CHECK: begin
                if (bc_valid) begin
                    nxt = PH_RECV;
                end else if (bc_fail) begin
                    nxt     = PH_SLEEP;
                    tmp_clr = 1'b1;
                end
            end
            PH_RECV:  if (host_ack) nxt = PH_SLEEP;
            default:  nxt = PH_SLEEP;
        endcase
        enter_sleep = (nxt == PH_SLEEP) && (phase != PH_SLEEP);
        enter_start = (nxt == PH_START) && (phase != PH_START);
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_SLEEP;
        else     phase <= nxt;
    end
endmodule

// File: rtl/rx_poll_ctrl.sv
module rx_poll_ctrl
    import rx_poll_pkg::*;
#(
    parameter int unsigned TICK_UNIT      = 1024,
    parameter int unsigned STARTUP_CYCLES = 16,
    parameter logic [4:0]  RST_SLEEP      = 5'd11
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [4:0] cfg_sleep,
    input  logic       cfg_xstd,
    input  logic       cfg_xtmp,
    input  logic       bc_pass,
    input  logic       bc_fail,
    input  logic       bc_valid,
    input  logic       host_ack,
    output logic       proc_en,
    output logic       wake_o,
    output logic [1:0] phase_o
);
    localparam int unsigned SLEEP_MAX = 31 * EXT_MULT * TICK_UNIT;
    localparam int unsigned TW        = $clog2(SLEEP_MAX + 1);
    localparam int unsigned SW        = $clog2(STARTUP_CYCLES + 1);
    localparam logic [TW-1:0] SLEEP_RST_LEN = TW'(sleep_len(RST_SLEEP, 1'b0, TICK_UNIT));
    localparam logic [SW-1:0] START_LEN     = SW'(STARTUP_CYCLES);

    poll_cfg_t     wr_cfg, cfg_nxt;
    phase_e        phase;
    logic          enter_sleep, enter_start, tmp_clr;
    logic          sleep_done, start_done;
    logic          perm_q, wake_perm;
    logic [TW-1:0] sleep_load;
    logic          unused_pass;

    assign unused_pass  = bc_pass;   // a pass keeps the check running: no action
    assign wr_cfg.word  = cfg_sleep;
    assign wr_cfg.x_std = cfg_xstd;
    assign wr_cfg.x_tmp = cfg_xtmp;
    assign wake_perm    = cfg_we && (cfg_sleep != SLEEP_FOREVER);
    assign sleep_load   = TW'(sleep_len(cfg_nxt.word, cfg_nxt.x_std | cfg_nxt.x_tmp, TICK_UNIT));

    rx_poll_cfg #(.RST_WORD(RST_SLEEP)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .wr      (wr_cfg),
        .tmp_clr (tmp_clr),
        .cfg_nxt (cfg_nxt)
    );

    rx_poll_timer #(.W(TW), .RST_VAL(SLEEP_RST_LEN)) u_sleep_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (enter_sleep),
        .load_val (sleep_load),
        .run      (phase == PH_SLEEP),
        .expired  (sleep_done)
    );

    rx_poll_timer #(.W(SW), .RST_VAL(START_LEN)) u_start_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (enter_start),
        .load_val (START_LEN),
        .run      (phase == PH_START),
        .expired  (start_done)
    );

    rx_poll_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .sleep_done  (sleep_done),
        .start_done  (start_done),
        .perm_q      (perm_q),
        .wake_perm   (wake_perm),
        .bc_fail     (bc_fail),
        .bc_valid    (bc_valid),
        .host_ack    (host_ack),
        .phase       (phase),
        .enter_sleep (enter_sleep),
        .enter_start (enter_start),
        .tmp_clr     (tmp_clr)
    );

    // permanent-sleep flag is sampled when a sleep is entered
    always_ff @(posedge clk) begin
        if (rst)              perm_q <= (RST_SLEEP == SLEEP_FOREVER);
        else if (enter_sleep) perm_q <= (cfg_nxt.word == SLEEP_FOREVER);
        else if (enter_start) perm_q <= 1'b0;
    end

    assign proc_en = (phase != PH_SLEEP);
    assign wake_o  = (phase == PH_RECV);
    assign phase_o = phase;
endmodule

// File: rtl/rx_poll_chk.sv
module rx_poll_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] phase,
    input logic       proc_en,
    input logic       wake_o,
    input logic       cfg_we,
    input logic [4:0] cfg_sleep,
    input logic       bc_fail,
    input logic       bc_valid,
    input logic       host_ack,
    input logic       perm_q,
    input logic       xtmp_q
);
    p_sleep_next_r1: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd0 |=> (phase == 2'd0 || phase == 2'd1));
    p_start_next_r1: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd1 |=> (phase == 2'd1 || phase == 2'd2));
    p_recv_next_r1: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd3 |=> (phase == 2'd3 || phase == 2'd0));
    p_sleep_off_r2: assert property (@(posedge clk) disable iff (rst)
        phase == 2'd0 |-> !proc_en);
    p_wake_en_r2: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> proc_en);
    p_fail_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && bc_fail && !bc_valid) |=> phase == 2'd0);
    p_tmp_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && bc_fail && !bc_valid && !cfg_we) |=> !xtmp_q);
    p_valid_recv_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd2 && bc_valid) |=> wake_o);
    p_wake_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wake_o && !host_ack) |=> wake_o);
    p_perm_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && perm_q && !cfg_we) |=> phase == 2'd0);
    p_perm_exit_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == 2'd0 && perm_q && cfg_we && cfg_sleep != 5'h1F) |=> phase == 2'd1);
endmodule

bind rx_poll_ctrl rx_poll_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase_o),
    .proc_en   (proc_en),
    .wake_o    (wake_o),
    .cfg_we    (cfg_we),
    .cfg_sleep (cfg_sleep),
    .bc_fail   (bc_fail),
    .bc_valid  (bc_valid),
    .host_ack  (host_ack),
    .perm_q    (perm_q),
    .xtmp_q    (u_cfg.cfg_nxt.x_tmp)
);

// File: tb/rx_poll_ctrl_tb.sv
module rx_poll_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT       = 4;
    localparam int STARTUP    = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0, cfg_xstd = 1'b0, cfg_xtmp = 1'b0;
    logic [4:0] cfg_sleep = 5'd0;
    logic       bc_pass = 1'b0, bc_fail = 1'b0, bc_valid = 1'b0, host_ack = 1'b0;
    logic       proc_en, wake_o;
    logic [1:0] phase_o;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_poll_ctrl #(.TICK_UNIT(UNIT), .STARTUP_CYCLES(STARTUP), .RST_SLEEP(5'd1)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sleep(cfg_sleep),
        .cfg_xstd(cfg_xstd), .cfg_xtmp(cfg_xtmp), .bc_pass(bc_pass),
        .bc_fail(bc_fail), .bc_valid(bc_valid), .host_ack(host_ack),
        .proc_en(proc_en), .wake_o(wake_o), .phase_o(phase_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // count clocks spent in phase p, starting at the current negedge
    task automatic time_phase(input logic [1:0] p, output int n);
        n = 0;
        while (phase_o == p && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_phase(input logic [1:0] p);
        for (int i = 0; i < 5000 && phase_o != p; i++) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [4:0] w, input logic xs, input logic xt);
        cfg_we = 1'b1; cfg_sleep = w; cfg_xstd = xs; cfg_xtmp = xt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic fail_pulse();
        bc_fail = 1'b1;
        @(negedge clk);
        bc_fail = 1'b0;
    endtask

    task automatic sleep_after_fail(input int exp, input string req);
        int n;
        wait_phase(2'd2);
        fail_pulse();
        chk({req, " fail leads to sleep"}, phase_o, 0);
        time_phase(2'd0, n);
        chk({req, " sleep length"}, n, exp);
    endtask

    task automatic t_reset();
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R11 reset phase", phase_o, 0);
        chk("R11 reset wake", wake_o, 0);
        chk("R2 proc_en low in sleep", proc_en, 0);
        time_phase(2'd0, n);
        chk("R11 R3 first sleep length", n, UNIT);
        chk("R1 sleep then startup", phase_o, 1);
        chk("R2 proc_en high in startup", proc_en, 1);
        time_phase(2'd1, n);
        chk("R6 startup length", n, STARTUP);
        chk("R1 startup then check", phase_o, 2);
        chk("R2 proc_en high in check", proc_en, 1);
    endtask

    task automatic t_check_pulses();
        bc_pass = 1'b1;
        repeat (3) @(negedge clk);
        bc_pass = 1'b0;
        chk("R7 pass keeps check", phase_o, 2);
        sleep_after_fail(UNIT, "R7");
    endtask

    task automatic t_write_deferred();
        int n;
        wait_phase(2'd2);
        fail_pulse();
        @(negedge clk);                  // one sleep clock elapsed
        write_cfg(5'd2, 1'b0, 1'b0);     // written mid-sleep
        time_phase(2'd0, n);
        chk("R10 current sleep unchanged", n + 2, UNIT);
        sleep_after_fail(2 * UNIT, "R10 R3");
    endtask

    task automatic t_word_zero();
        wait_phase(2'd2);
        write_cfg(5'd0, 1'b0, 1'b0);
        sleep_after_fail(1, "R3 word0");
    endtask

    task automatic t_standard_ext();
        wait_phase(2'd2);
        write_cfg(5'd1, 1'b1, 1'b0);
        sleep_after_fail(8 * UNIT, "R4 first");
        sleep_after_fail(8 * UNIT, "R4 second");
    endtask

    task automatic t_temp_ext();
        int n;
        wait_phase(2'd2);
        write_cfg(5'd1, 1'b0, 1'b1);
        bc_valid = 1'b1;
        @(negedge clk);
        bc_valid = 1'b0;
        chk("R8 valid to receiving", phase_o, 3);
        repeat (4) @(negedge clk);
        chk("R8 wake held", wake_o, 1);
        chk("R2 proc_en in receiving", proc_en, 1);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        chk("R8 ack to sleep", phase_o, 0);
        chk("R8 wake dropped", wake_o, 0);
        time_phase(2'd0, n);
        chk("R5 extended while passing", n, 8 * UNIT);
        sleep_after_fail(UNIT, "R5 cleared on fail");
        sleep_after_fail(UNIT, "R5 stays cleared");
    endtask

    task automatic t_valid_priority();
        int n;
        wait_phase(2'd2);
        bc_valid = 1'b1; bc_fail = 1'b1;
        @(negedge clk);
        bc_valid = 1'b0; bc_fail = 1'b0;
        chk("R8 valid over fail", phase_o, 3);
        host_ack = 1'b1;
        @(negedge clk);
        host_ack = 1'b0;
        time_phase(2'd0, n);
        chk("R8 sleep after ack", n, UNIT);
    endtask

    task automatic t_permanent();
        int n;
        wait_phase(2'd2);
        write_cfg(5'd31, 1'b0, 1'b0);
        fail_pulse();
        n = 0;
        for (int i = 0; i < 300; i++) begin
            bc_fail = i[0]; bc_pass = i[1]; bc_valid = i[2];
            @(negedge clk);
            if (phase_o == 2'd0) n++;
        end
        bc_fail = 1'b0; bc_pass = 1'b0; bc_valid = 1'b0;
        chk("R9 R12 permanent sleep holds", n, 300);
        write_cfg(5'd2, 1'b0, 1'b0);
        chk("R9 leave permanent at once", phase_o, 1);
        sleep_after_fail(2 * UNIT, "R9 R10 new word");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_check_pulses();
        t_write_deferred();
        t_word_zero();
        t_standard_ext();
        t_temp_ext();
        t_valid_priority();
        t_permanent();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule